// File: doc/BRIEF.md
# Interleaved Block-Fill Memory Sequencer

This block serves cache-line fill requests from a set of banks, each one word wide. A requester presents a block address. The sequencer spends a fixed address time sending that address, starts the bank accesses, and waits for them to finish. It then returns the block's words one by one over a single one-word bus, one transfer period apiece. Each bank has its own access timer. A bank is chosen by the low bits of the word address, and because the bank count is a power of two this selection is a bit slice with no divider.

In the default interleaved variant, every bank receives the address in the same cycle and all the accesses overlap. A block therefore costs one address time, one access time and one transfer time per word. A parameter selects a sequential variant for comparison: that variant runs a full address, access and transfer sequence for each word in turn. Banks are synchronous arrays whose contents are loaded with a fixed pattern at reset, so that every returned word can be predicted. The block size must not exceed the bank count, and both must be powers of two of at least 2.

Top module: `ilv_fill_engine`

## Requirements
- R1: A block address B with word index j maps to word address A = B*BLK_WORDS + j. The word is held in bank A mod BANKS, at row A / BANKS. With the defaults (16-bit words, 8-bit word addresses) the word stored at A reads as {~A[7:0], A[7:0]}.
- R2: `req_ready` is high whenever no block is in progress. It is low from the cycle after a request is accepted until the cycle that carries the final word.
- R3: In interleaved mode, word k (counting from 0) of a block is presented exactly ADDR_CYC + ACC_CYC + (k+1)*XFER_CYC cycles after the accepting clock edge. With the defaults that is 32, 36, 40 and 44 cycles.
- R4: Words return in ascending index order 0..BLK_WORDS-1, with `rsp_index` carrying the index. `rsp_last` is high only with index BLK_WORDS-1.
- R5: In sequential mode, word k is presented exactly (k+1)*(ADDR_CYC + ACC_CYC + XFER_CYC) cycles after the accepting edge. With the defaults that is 32, 64, 96 and 128 cycles.
- R6: A request held on the request port while a block is in progress is ignored. It does not change the block in flight, and no extra block follows once that request is withdrawn.
- R7: After reset, `rsp_valid` is low and `req_ready` is high.
- R8: `rsp_valid` is a one-cycle strobe, and each accepted request yields exactly BLK_WORDS strobes.
- R9: A request presented in the cycle that carries `rsp_last` is accepted at the next clock edge, and its timing counts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Sequencer idle; a request is accepted this cycle |
| req_blk | input | ADDR_W-log2(BLK_WORDS) | Block address |
| rsp_valid | output | 1 | Word strobe |
| rsp_data | output | WORD_W | Returned word |
| rsp_index | output | log2(BLK_WORDS) | Index of the word within the block |
| rsp_last | output | 1 | Final word of the block |

## Verification
The bench measures the exact cycle of every word strobe against the overlapped formula. If the design serialised its bank accesses, or lost or gained a cycle at a phase boundary, the strobes would land off schedule. The bench also compares data against the bank-mapping pattern, so a design that sliced the wrong address bits or took data from the wrong bank would return foreign words. It holds a second request on the port during a fill, and one built wrongly would restart the banks or append a phantom block. It also issues a request in the same cycle as the last word, which catches a sequencer that drops that request or adds a dead cycle. A second instance runs the sequential variant, where a wrong per-word restart shows up as drifting word times.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_ACCESS,
        SQ_XFER
    } sq_state_e;
endpackage

// File: rtl/ibs_addr_map.sv
module ibs_addr_map #(
    parameter int ADDR_W    = 8,
    parameter int BANKS     = 4,
    parameter int BLK_WORDS = 4,
    localparam int BSEL_W   = $clog2(BANKS),
    localparam int IDX_W    = $clog2(BLK_WORDS),
    localparam int BLK_AW   = ADDR_W - IDX_W,
    localparam int ROW_W    = ADDR_W - BSEL_W
) (
    input  logic [BLK_AW-1:0] blk,
    input  logic [IDX_W-1:0]  idx,
    output logic [ROW_W-1:0]  row,
    output logic [BSEL_W-1:0] bank
);
    logic [ADDR_W-1:0] waddr;

    // Word address from block and index; low bits pick the bank, the rest the row.
    always_comb begin
        waddr = {blk, idx};
        bank  = waddr[BSEL_W-1:0];
        row   = waddr[ADDR_W-1:BSEL_W];
    end
endmodule

// File: rtl/ibs_bank.sv
module ibs_bank #(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 8,
    parameter int BANKS   = 4,
    parameter int BANK_ID = 0,
    parameter int ACC_CYC = 24,
    localparam int BSEL_W = $clog2(BANKS),
    localparam int ROW_W  = ADDR_W - BSEL_W,
    localparam int ROWS   = 1 << ROW_W,
    localparam int TMR_W  = $clog2(ACC_CYC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  row,
    output logic              done,
    output logic [WORD_W-1:0] dout
);
    typedef struct packed {
        logic              busy;
        logic [TMR_W-1:0]  tmr;
        logic [WORD_W-1:0] dout;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [WORD_W-1:0] mem [ROWS];

    function automatic logic [WORD_W-1:0] fill_pat(input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] p;
        for (int i = 0; i < WORD_W; i++) begin
            p[i] = (i < ADDR_W) ? a[i % ADDR_W] : ~a[i % ADDR_W];
        end
        return p;
    endfunction

    // Array contents: a fixed, predictable pattern loaded at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= fill_pat({ROW_W'(r), BSEL_W'(BANK_ID)});
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.tmr  = TMR_W'(ACC_CYC - 1);
            st_d.dout = mem[row];
        end else if (st_q.busy) begin
            if (st_q.tmr == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.tmr = st_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.busy && (st_q.tmr == '0);
    assign dout = st_q.dout;

    // R3: the access-complete indication lasts a single cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a bank is never restarted while its access is running
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !start);
endmodule

// File: rtl/ibs_sequencer.sv
module ibs_sequencer
    import ibs_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int BANKS       = 4,
    parameter int BLK_WORDS   = 4,
    parameter int ADDR_CYC    = 4,
    parameter int XFER_CYC    = 4,
    parameter bit INTERLEAVED = 1'b1,
    localparam int BSEL_W     = $clog2(BANKS),
    localparam int IDX_W      = $clog2(BLK_WORDS),
    localparam int BLK_AW     = ADDR_W - IDX_W,
    localparam int CNT_MAX    = (ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC,
    localparam int CNT_W      = $clog2(CNT_MAX) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BLK_AW-1:0] req_blk,
    output logic              req_ready,
    output logic [BLK_AW-1:0] cur_blk,
    output logic [IDX_W-1:0]  cur_idx,
    input  logic [BSEL_W-1:0] cur_bank,
    output logic [BANKS-1:0]  bank_start,
    input  logic              sel_done,
    input  logic [WORD_W-1:0] sel_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic [IDX_W-1:0]  rsp_index,
    output logic              rsp_last
);
    typedef struct packed {
        sq_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BLK_AW-1:0] blk;
        logic [IDX_W-1:0]  idx;
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_data;
        logic [IDX_W-1:0]  rsp_index;
        logic              rsp_last;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    launch;
    logic    at_final;

    // Start mask: overlapped variant opens every bank, sequential only the addressed one.
    generate
        if (INTERLEAVED) begin : g_all_banks
            assign bank_start = {BANKS{launch}};
        end else begin : g_one_bank
            assign bank_start = launch ? (BANKS'(1) << cur_bank) : '0;
        end
    endgenerate

    assign at_final = (st_q.idx == IDX_W'(BLK_WORDS - 1));

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_last  = 1'b0;
        launch         = 1'b0;
        unique case (st_q.state)
            SQ_IDLE: begin
                if (req_valid) begin
                    st_d.state = SQ_ADDR;
                    st_d.cnt   = CNT_W'(ADDR_CYC - 1);
                    st_d.blk   = req_blk;
                    st_d.idx   = '0;
                end
            end
            SQ_ADDR: begin
                if (st_q.cnt == '0) begin
                    launch     = 1'b1;
                    st_d.state = SQ_ACCESS;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            SQ_ACCESS: begin
                if (sel_done) begin
                    st_d.state = SQ_XFER;
                    st_d.cnt   = CNT_W'(XFER_CYC - 1);
                end
            end
            SQ_XFER: begin
                if (st_q.cnt == '0) begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_data  = sel_data;
                    st_d.rsp_index = st_q.idx;
                    st_d.rsp_last  = at_final;
                    if (at_final) begin
                        st_d.state = SQ_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                        if (INTERLEAVED) begin
                            st_d.cnt = CNT_W'(XFER_CYC - 1);
                        end else begin
                            st_d.state = SQ_ADDR;
                            st_d.cnt   = CNT_W'(ADDR_CYC - 1);
                        end
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= SQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.state == SQ_IDLE);
    assign cur_blk   = st_q.blk;
    assign cur_idx   = st_q.idx;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_index = st_q.rsp_index;
    assign rsp_last  = st_q.rsp_last;

    // R2: the block address stays frozen while a fill is in progress
    p_blk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready && !$past(req_ready) |-> $stable(cur_blk));
endmodule

// File: rtl/ilv_fill_engine.sv
module ilv_fill_engine #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int BANKS       = 4,
    parameter int BLK_WORDS   = 4,
    parameter int ADDR_CYC    = 4,
    parameter int ACC_CYC     = 24,
    parameter int XFER_CYC    = 4,
    parameter bit INTERLEAVED = 1'b1,
    localparam int BSEL_W     = $clog2(BANKS),
    localparam int IDX_W      = $clog2(BLK_WORDS),
    localparam int BLK_AW     = ADDR_W - IDX_W,
    localparam int ROW_W      = ADDR_W - BSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BLK_AW-1:0] req_blk,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic [IDX_W-1:0]  rsp_index,
    output logic              rsp_last
);
    logic [BLK_AW-1:0] cur_blk;
    logic [IDX_W-1:0]  cur_idx;
    logic [ROW_W-1:0]  row;
    logic [BSEL_W-1:0] cur_bank;
    logic [BANKS-1:0]  bank_start;
    logic [BANKS-1:0]  bank_done;
    logic [WORD_W-1:0] bank_dout [BANKS];
    logic              sel_done;
    logic [WORD_W-1:0] sel_data;

    ibs_addr_map #(
        .ADDR_W    (ADDR_W),
        .BANKS     (BANKS),
        .BLK_WORDS (BLK_WORDS)
    ) u_map (
        .blk  (cur_blk),
        .idx  (cur_idx),
        .row  (row),
        .bank (cur_bank)
    );

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            ibs_bank #(
                .WORD_W  (WORD_W),
                .ADDR_W  (ADDR_W),
                .BANKS   (BANKS),
                .BANK_ID (b),
                .ACC_CYC (ACC_CYC)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .start (bank_start[b]),
                .row   (row),
                .done  (bank_done[b]),
                .dout  (bank_dout[b])
            );
        end
    endgenerate

    assign sel_done = bank_done[cur_bank];
    assign sel_data = bank_dout[cur_bank];

    ibs_sequencer #(
        .WORD_W      (WORD_W),
        .ADDR_W      (ADDR_W),
        .BANKS       (BANKS),
        .BLK_WORDS   (BLK_WORDS),
        .ADDR_CYC    (ADDR_CYC),
        .XFER_CYC    (XFER_CYC),
        .INTERLEAVED (INTERLEAVED)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .req_ready  (req_ready),
        .cur_blk    (cur_blk),
        .cur_idx    (cur_idx),
        .cur_bank   (cur_bank),
        .bank_start (bank_start),
        .sel_done   (sel_done),
        .sel_data   (sel_data),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_index  (rsp_index),
        .rsp_last   (rsp_last)
    );

    // R4: the final-word flag coincides with the highest index
    p_last_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_last == (rsp_index == IDX_W'(BLK_WORDS - 1))));
    // R2: no new request can be taken while words are still owed
    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last |-> !req_ready);
    // R4: successive words of a block step the index by one
    p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last |=> (!rsp_valid || rsp_index != '0));

    generate
        if (XFER_CYC > 1) begin : g_pulse_chk
            // R8: word strobes are isolated single-cycle pulses
            p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_valid |=> !rsp_valid);
        end
    endgenerate
endmodule

// File: tb/tb_ilv_fill_engine.sv
module tb_ilv_fill_engine;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int BANKS  = 4;
    localparam int BLKW   = 4;
    localparam int TA     = 4;
    localparam int TACC   = 24;
    localparam int TX     = 4;
    localparam int BLK_AW = 6;
    localparam int NVEC   = 6;
    localparam logic [BLK_AW-1:0] VEC [NVEC] = '{6'd0, 6'd1, 6'd5, 6'd21, 6'd42, 6'd63};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid_a = 1'b0, req_valid_b = 1'b0;
    logic [BLK_AW-1:0] req_blk = '0;
    logic rdy_a, rdy_b, rv_a, rv_b, rl_a, rl_b;
    logic [WORD_W-1:0] rd_a, rd_b;
    logic [1:0] ri_a, ri_b;
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ilv_fill_engine #(.INTERLEAVED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_a), .req_ready(rdy_a),
        .req_blk(req_blk), .rsp_valid(rv_a), .rsp_data(rd_a),
        .rsp_index(ri_a), .rsp_last(rl_a));

    ilv_fill_engine #(.INTERLEAVED(1'b0)) dut_ni (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_b), .req_ready(rdy_b),
        .req_blk(req_blk), .rsp_valid(rv_b), .rsp_data(rd_b),
        .rsp_index(ri_b), .rsp_last(rl_b));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input logic [7:0] a);
        return {~a, a};
    endfunction

    // Issue one block at the current negedge and check every returned word.
    task automatic fetch(input bit ni, input logic [BLK_AW-1:0] blk, input bit junk);
        int c0;
        int k;
        bit got_last;
        logic [7:0] wa;
        int exp_t;
        chk(ni ? rdy_b : rdy_a, 1, "R2 ready while idle");
        req_blk = blk;
        if (ni) req_valid_b = 1'b1; else req_valid_a = 1'b1;
        @(negedge clk);
        c0 = cyc;
        if (junk) begin
            req_blk = blk ^ 6'h2A;
        end else begin
            req_valid_a = 1'b0;
            req_valid_b = 1'b0;
        end
        chk(ni ? rdy_b : rdy_a, 0, "R2 ready low after accept");
        k = 0;
        got_last = 1'b0;
        while (!got_last && (cyc - c0) < 400) begin
            if (junk && (cyc - c0) == 20) begin
                req_valid_a = 1'b0;
                req_valid_b = 1'b0;
            end
            if (ni ? rv_b : rv_a) begin
                wa = {blk, 2'(k)};
                exp_t = ni ? (k + 1) * (TA + TACC + TX) : TA + TACC + (k + 1) * TX;
                chk(cyc - c0, exp_t, ni ? "R5 word time" : "R3 word time");
                chk(ni ? rd_b : rd_a, word_of(wa), "R1 word data");
                chk(ni ? ri_b : ri_a, k, "R4 word index");
                chk(ni ? rl_b : rl_a, (k == BLKW - 1) ? 1 : 0, "R4 last flag");
                if (ni ? rl_b : rl_a) begin
                    got_last = 1'b1;
                    chk(ni ? rdy_b : rdy_a, 1, "R9 ready with last word");
                end
                k++;
            end
            if (!got_last) @(negedge clk);
        end
        chk(k, BLKW, "R8 strobes per block");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(rv_a, 0, "R7 strobe low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(rv_a, 0, "R7 strobe low after reset");
        chk(rdy_a, 1, "R7 ready after reset");
        chk(rv_b, 0, "R7 strobe low after reset (seq)");
        chk(rdy_b, 1, "R7 ready after reset (seq)");

        // Vector table walk, interleaved; each fetch starts in the cycle holding the
        // previous last word, so every block after the first is back-to-back (R9).
        for (int v = 0; v < NVEC; v++) begin
            fetch(1'b0, VEC[v], 1'b0);
        end
        @(negedge clk);

        // R5: sequential variant, two blocks
        fetch(1'b1, 6'd9, 1'b0);
        fetch(1'b1, 6'd50, 1'b0);
        @(negedge clk);

        // R6: a competing request held during a fill is ignored
        fetch(1'b0, 6'd17, 1'b1);
        @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            chk(rv_a, 0, "R6 no phantom block");
            @(negedge clk);
        end
        chk(rdy_a, 1, "R6 idle after ignored request");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule